// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the software-facing side of a platform interrupt controller. It accepts 32-bit word accesses on a simple request/response port and steers each one to one of four address windows, each placed by its own base-address parameter: one priority word per interrupt source, a read-only view of the pending bits, a block of enable words for each target context, and a small window per context with a threshold register and a claim/complete register.

The block holds the priority, enable and threshold state and drives it to the interrupt core as flat vectors. The core's pending vector and its claim result come back as inputs. A read of a context's claim register raises a one-cycle claim strobe toward the core and returns the source number the core offers. A write to the same register raises a one-cycle complete strobe that carries the written source number. The selection logic inside the core is not part of this block.

Every request is accepted in the cycle it is presented and is answered one cycle later. Reads of anything that is not a register return zero. Writes that break the access rules leave all state untouched.

Top module: `irq_regfront`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high in the following cycle, and `rsp_valid` is low in every other cycle. A write's response carries `rsp_rdata` = 0.
- R2: An access whose address has bits [1:0] not equal to 00 reads as 0, changes no register and raises neither strobe. This applies even when the address falls inside a register window.
- R3: The priority window starts at `PRIO_BASE`, and the word at `PRIO_BASE + 4*n` holds the priority of source n+1, for n from 0 to NUM_SRC-2. A write keeps only data bits [2:0], and a read returns them zero-extended. Source s drives `src_prio[3*s +: 3]`, and source 0 always reads as priority 0.
- R4: The pending window at `PEND_BASE` has ceil(NUM_SRC/32) words. Bit b of word w reads `pend_bits[32*w+b]` as sampled in the request cycle, and bits for sources at or above NUM_SRC read 0. Writes to this window change nothing.
- R5: The enable window for context c starts at `EN_BASE + c*EN_STRIDE`, and EN_STRIDE is a power of two. Word w of that block sits at offset 4*w, and its bit b enables source 32*w+b for that context. Enable state is driven on `src_en[c*NUM_SRC + s]`, and bits for sources at or above NUM_SRC read 0.
- R6: An enable access whose word index is ceil(NUM_SRC/32) or higher reads 0 and is ignored on write.
- R7: The threshold of context c is at `CTX_BASE + c*CTX_STRIDE`. A write is stored only when the full 32-bit value is at most NUM_LEVELS; a larger value leaves the threshold unchanged. The threshold drives `ctx_thr[3*c +: 3]`.
- R8: A read of `CTX_BASE + c*CTX_STRIDE + 4` raises `claim_stb` for exactly the request cycle, with `claim_ctx` = c. The response data is `claim_id` as presented in that cycle, zero-extended.
- R9: A write to `CTX_BASE + c*CTX_STRIDE + 4` with data below NUM_SRC raises `cmpl_stb` in the request cycle, with `cmpl_ctx` = c and `cmpl_id` = the data. Larger data raises no strobe. Claim and complete strobes are never high together.
- R10: An aligned read of any other address returns 0, and an aligned write to any other address changes nothing. Other addresses include offsets other than 0 and 4 in a context window, and anything outside the four windows.
- R11: After reset all priorities, enables and thresholds are 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| pend_bits | input | NUM_SRC | Pending vector from the interrupt core |
| claim_stb | output | 1 | Claim request to the core |
| claim_ctx | output | CTX_W | Context being claimed |
| claim_id | input | ID_W | Source the core offers for claim_ctx |
| cmpl_stb | output | 1 | Completion notice to the core |
| cmpl_ctx | output | CTX_W | Context completing |
| cmpl_id | output | ID_W | Source being completed |
| src_prio | output | NUM_SRC*3 | Per-source priority |
| src_en | output | NUM_CTX*NUM_SRC | Per-context enable bits |
| ctx_thr | output | NUM_CTX*3 | Per-context threshold |

## Verification
Two events can meet in one cycle. A pending-window read can be accepted in the same cycle that the core changes `pend_bits`. A claim read can also arrive just as the core presents a new `claim_id`. The bench changes these inputs at the same edge as the read request. Its model expects the response to carry the values present in the request cycle, not those of the cycle before or after. Back-to-back claims and writes immediately followed by reads of the same register are also run, and the bench checks them against the per-cycle strobe and response expectations.

// File: rtl/irq_rf_pkg.sv
`timescale 1ns/1ps
package irq_rf_pkg;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_PRIO  = 3'd1,
    RG_PEND  = 3'd2,
    RG_EN    = 3'd3,
    RG_THR   = 3'd4,
    RG_CLAIM = 3'd5
  } region_e;

  function automatic logic word_aligned(input logic [31:0] a);
    return a[1:0] == 2'b00;
  endfunction

  function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                     input logic [31:0] span);
    return (a >= base) && ((a - base) < span);
  endfunction

  function automatic logic [31:0] word_index(input logic [31:0] off);
    return off >> 2;
  endfunction

  function automatic logic thr_accept(input logic [31:0] val, input logic [31:0] levels);
    return val <= levels;
  endfunction

  function automatic logic id_accept(input logic [31:0] val, input logic [31:0] nsrc);
    return val < nsrc;
  endfunction

endpackage

// File: rtl/irq_rf_decode.sv
`timescale 1ns/1ps
module irq_rf_decode
  import irq_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NUM_SRC    = 40,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned PRIO_BASE  = 32'h0000_0004,
  parameter int unsigned PEND_BASE  = 32'h0000_1000,
  parameter int unsigned EN_BASE    = 32'h0000_2000,
  parameter int unsigned EN_STRIDE  = 128,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 4096,
  localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned ID_W      = $clog2(NUM_SRC),
  localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rg,
  output logic [ID_W-1:0]   d_src,
  output logic [WORD_W-1:0] d_word,
  output logic [CTX_W-1:0]  d_ctx
);

  localparam int unsigned PRIO_SPAN = (NUM_SRC - 1) * 4;
  localparam int unsigned PEND_SPAN = NUM_WORDS * 4;
  localparam int unsigned EN_SPAN   = NUM_CTX * EN_STRIDE;
  localparam int unsigned CTX_SPAN  = NUM_CTX * CTX_STRIDE;
  localparam int unsigned EN_SH     = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH    = $clog2(CTX_STRIDE);

  logic [31:0] a32;
  logic [31:0] en_w;
  logic [31:0] ctx_sub;

  assign a32 = 32'(addr);

  always_comb begin
    rg      = RG_NONE;
    d_src   = '0;
    d_word  = '0;
    d_ctx   = '0;
    en_w    = (a32 - EN_BASE) & (EN_STRIDE - 1);
    en_w    = word_index(en_w);
    ctx_sub = (a32 - CTX_BASE) & (CTX_STRIDE - 1);
    if (word_aligned(a32)) begin
      if (in_window(a32, PRIO_BASE, PRIO_SPAN)) begin
        rg    = RG_PRIO;
        d_src = ID_W'(word_index(a32 - PRIO_BASE) + 32'd1);
      end else if (in_window(a32, PEND_BASE, PEND_SPAN)) begin
        rg     = RG_PEND;
        d_word = WORD_W'(word_index(a32 - PEND_BASE));
      end else if (in_window(a32, EN_BASE, EN_SPAN)) begin
        if (en_w < NUM_WORDS) begin
          rg     = RG_EN;
          d_word = WORD_W'(en_w);
          d_ctx  = CTX_W'((a32 - EN_BASE) >> EN_SH);
        end
      end else if (in_window(a32, CTX_BASE, CTX_SPAN)) begin
        d_ctx = CTX_W'((a32 - CTX_BASE) >> CTX_SH);
        if (ctx_sub == 32'd0)      rg = RG_THR;
        else if (ctx_sub == 32'd4) rg = RG_CLAIM;
      end
    end
  end

endmodule

// File: rtl/irq_rf_store.sv
`timescale 1ns/1ps
module irq_rf_store
  import irq_rf_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 40,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned NUM_LEVELS = 7,
  localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned ID_W      = $clog2(NUM_SRC),
  localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned THR_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  region_e                     rg,
  input  logic [ID_W-1:0]             d_src,
  input  logic [WORD_W-1:0]           d_word,
  input  logic [CTX_W-1:0]            d_ctx,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rd_reg,
  output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
  output logic [NUM_CTX*NUM_SRC-1:0]  en_flat,
  output logic [NUM_CTX*THR_W-1:0]    thr_flat
);

  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][THR_W-1:0]   thr_q;
  logic                            thr_ok;
  logic [NUM_WORDS*32-1:0]         en_pad;
  logic [31:0]                     en_word;

  assign thr_ok = thr_accept(wdata, NUM_LEVELS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      for (int s = 1; s < NUM_SRC; s++) begin
        if (rg == RG_PRIO && d_src == ID_W'(s)) prio_q[s] <= wdata[PRIO_W-1:0];
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (rg == RG_EN && d_ctx == CTX_W'(c) && d_word == WORD_W'(s / 32))
            en_q[c][s] <= wdata[s % 32];
        end
        if (rg == RG_THR && d_ctx == CTX_W'(c) && thr_ok) thr_q[c] <= THR_W'(wdata);
      end
    end
  end

  always_comb begin
    en_pad              = '0;
    en_pad[NUM_SRC-1:0] = en_q[d_ctx];
    en_word             = en_pad[{d_word, 5'b0} +: 32];
  end

  always_comb begin
    case (rg)
      RG_PRIO: rd_reg = 32'(prio_q[d_src]);
      RG_EN:   rd_reg = en_word;
      RG_THR:  rd_reg = 32'(thr_q[d_ctx]);
      default: rd_reg = '0;
    endcase
  end

  assign prio_flat = prio_q;
  assign en_flat   = en_q;
  assign thr_flat  = thr_q;

  for (genvar s = 1; s < NUM_SRC; s++) begin : g_prio_chk
    p_prio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && rg == RG_PRIO && d_src == ID_W'(s)) |=> $stable(prio_q[s]));
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr_chk
    p_thr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rg == RG_THR && d_ctx == CTX_W'(c) && wdata > NUM_LEVELS) |=> $stable(thr_q[c]));
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && rg == RG_EN && d_ctx == CTX_W'(c)) |=> $stable(en_q[c]));
  end

endmodule

// File: rtl/irq_rf_resp.sv
`timescale 1ns/1ps
module irq_rf_resp
  import irq_rf_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 40,
  localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned ID_W      = $clog2(NUM_SRC),
  localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  region_e            rg,
  input  logic [WORD_W-1:0]  d_word,
  input  logic [31:0]        rd_reg,
  input  logic [NUM_SRC-1:0] pend_bits,
  input  logic [ID_W-1:0]    claim_id,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata
);

  logic [NUM_WORDS*32-1:0] pend_pad;
  logic [31:0]             rd_next;

  always_comb begin
    pend_pad              = '0;
    pend_pad[NUM_SRC-1:0] = pend_bits;
    case (rg)
      RG_PEND:  rd_next = pend_pad[{d_word, 5'b0} +: 32];
      RG_CLAIM: rd_next = 32'(claim_id);
      default:  rd_next = rd_reg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_next : 32'd0;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_only_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  p_write_rsp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'd0));

endmodule

// File: rtl/irq_regfront.sv
`timescale 1ns/1ps
module irq_regfront
  import irq_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned NUM_SRC    = 40,
  parameter int unsigned NUM_CTX    = 2,
  parameter int unsigned NUM_LEVELS = 7,
  parameter int unsigned PRIO_BASE  = 32'h0000_0004,
  parameter int unsigned PEND_BASE  = 32'h0000_1000,
  parameter int unsigned EN_BASE    = 32'h0000_2000,
  parameter int unsigned EN_STRIDE  = 128,
  parameter int unsigned CTX_BASE   = 32'h0020_0000,
  parameter int unsigned CTX_STRIDE = 4096,
  localparam int unsigned PRIO_W    = 3,
  localparam int unsigned NUM_WORDS = (NUM_SRC + 31) / 32,
  localparam int unsigned ID_W      = $clog2(NUM_SRC),
  localparam int unsigned WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned THR_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [31:0]                 req_wdata,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_rdata,
  input  logic [NUM_SRC-1:0]          pend_bits,
  output logic                        claim_stb,
  output logic [CTX_W-1:0]            claim_ctx,
  input  logic [ID_W-1:0]             claim_id,
  output logic                        cmpl_stb,
  output logic [CTX_W-1:0]            cmpl_ctx,
  output logic [ID_W-1:0]             cmpl_id,
  output logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  output logic [NUM_CTX*NUM_SRC-1:0]  src_en,
  output logic [NUM_CTX*THR_W-1:0]    ctx_thr
);

  region_e           rg;
  logic [ID_W-1:0]   d_src;
  logic [WORD_W-1:0] d_word;
  logic [CTX_W-1:0]  d_ctx;
  logic [31:0]       rd_reg;
  logic              acc_rd;
  logic              acc_wr;

  assign acc_rd = req_valid && !req_write;
  assign acc_wr = req_valid && req_write;

  irq_rf_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_decode (
    .addr(req_addr), .rg(rg), .d_src(d_src), .d_word(d_word), .d_ctx(d_ctx)
  );

  irq_rf_store #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .NUM_LEVELS(NUM_LEVELS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr(acc_wr), .rg(rg), .d_src(d_src),
    .d_word(d_word), .d_ctx(d_ctx), .wdata(req_wdata), .rd_reg(rd_reg),
    .prio_flat(src_prio), .en_flat(src_en), .thr_flat(ctx_thr)
  );

  irq_rf_resp #(
    .NUM_SRC(NUM_SRC)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rg(rg), .d_word(d_word), .rd_reg(rd_reg), .pend_bits(pend_bits),
    .claim_id(claim_id), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // one strobe per accepted request cycle, toward the interrupt core
  assign claim_stb = acc_rd && (rg == RG_CLAIM);
  assign claim_ctx = d_ctx;
  assign cmpl_stb  = acc_wr && (rg == RG_CLAIM) && id_accept(req_wdata, NUM_SRC);
  assign cmpl_ctx  = d_ctx;
  assign cmpl_id   = ID_W'(req_wdata);

  p_claim_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_stb || cmpl_stb) |-> (req_addr[1:0] == 2'b00));
  p_misaligned_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && req_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'd0));
  p_claim_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |=> rsp_valid);
  p_claim_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> (req_valid && !req_write));
  p_strobes_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_stb && cmpl_stb));
  p_cmpl_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_stb |-> (req_wdata < NUM_SRC));

endmodule

// File: tb/irq_regfront_tb.sv
`timescale 1ns/1ps
module irq_regfront_tb;

  localparam int NS = 40, NC = 2, NW = 2, NL = 7;
  localparam int PB = 'h4, QB = 'h1000, EB = 'h2000, ES = 128, CB = 'h200000, CS = 'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NS-1:0] pend_bits = '0;
  logic [5:0]  claim_id = '0;
  logic        rsp_valid, claim_stb, cmpl_stb;
  logic [31:0] rsp_rdata;
  logic        claim_ctx, cmpl_ctx;
  logic [5:0]  cmpl_id;
  logic [NS*3-1:0]  src_prio;
  logic [NC*NS-1:0] src_en;
  logic [NC*3-1:0]  ctx_thr;

  irq_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pend_bits(pend_bits), .claim_stb(claim_stb),
    .claim_ctx(claim_ctx), .claim_id(claim_id), .cmpl_stb(cmpl_stb),
    .cmpl_ctx(cmpl_ctx), .cmpl_id(cmpl_id), .src_prio(src_prio),
    .src_en(src_en), .ctx_thr(ctx_thr)
  );

  int total = 0, bad = 0;
  bit done = 0;

  int prio_m[NS];
  bit en_m[NC][NS];
  int thr_m[NC];
  logic [NS-1:0] tb_pend = '0;
  int tb_cid = 0;
  bit exp_rv = 0;
  logic [31:0] exp_rd = '0;
  string exp_tag = "R1 idle";

  typedef enum {M_NONE, M_PRIO, M_PEND, M_EN, M_THR, M_CLAIM} mkind_e;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] prio_vec();
    logic [127:0] v = '0;
    for (int s = 0; s < NS; s++) v[s*3 +: 3] = 3'(prio_m[s]);
    return v;
  endfunction

  function automatic logic [127:0] en_vec();
    logic [127:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) v[c*NS + s] = en_m[c][s];
    return v;
  endfunction

  function automatic logic [127:0] thr_vec();
    logic [127:0] v = '0;
    for (int c = 0; c < NC; c++) v[c*3 +: 3] = 3'(thr_m[c]);
    return v;
  endfunction

  // independent address map, restated from the requirements
  function automatic void mdec(input longint a, output mkind_e k, output int idx,
                               output int c, output string tg);
    k = M_NONE; idx = 0; c = 0;
    if (a % 4 != 0) tg = "R2 misaligned";
    else if (a >= EB && a < EB + NC*ES) tg = "R6 enable word out of range";
    else tg = "R10 unmapped";
    if (a % 4 != 0) return;
    if (a >= PB && a < PB + (NS-1)*4) begin
      k = M_PRIO; idx = int'((a - PB) / 4) + 1; tg = "R3 priority";
    end else if (a >= QB && a < QB + NW*4) begin
      k = M_PEND; idx = int'((a - QB) / 4); tg = "R4 pending";
    end else if (a >= EB && a < EB + NC*ES) begin
      c = int'((a - EB) / ES); idx = int'(((a - EB) % ES) / 4);
      if (idx < NW) begin k = M_EN; tg = "R5 enable"; end
    end else if (a >= CB && a < CB + NC*CS) begin
      c = int'((a - CB) / CS);
      if ((a - CB) % CS == 0) begin k = M_THR; tg = "R7 threshold"; end
      else if ((a - CB) % CS == 4) begin k = M_CLAIM; tg = "R8 claim"; end
    end
  endfunction

  task automatic step(bit v, bit w, longint a, longint d);
    mkind_e k; int idx, c; string tg;
    logic [31:0] rd;
    bit cs, ms;
    @(negedge clk);
    chk(rsp_valid === exp_rv, "R1 rsp_valid", 128'(rsp_valid), 128'(exp_rv));
    chk(rsp_rdata === exp_rd, exp_tag, 128'(rsp_rdata), 128'(exp_rd));
    chk(128'(src_prio) === prio_vec(), "R3 src_prio", 128'(src_prio), prio_vec());
    chk(128'(src_en) === en_vec(), "R5 src_en", 128'(src_en), en_vec());
    chk(128'(ctx_thr) === thr_vec(), "R7 ctx_thr", 128'(ctx_thr), thr_vec());
    req_valid = v; req_write = w; req_addr = 24'(a); req_wdata = 32'(d);
    pend_bits = tb_pend; claim_id = 6'(tb_cid);
    #1;
    mdec(a, k, idx, c, tg);
    cs = v && !w && k == M_CLAIM;
    ms = v && w && k == M_CLAIM && d < NS;
    chk(claim_stb === cs, "R8 claim_stb", 128'(claim_stb), 128'(cs));
    if (cs) chk(int'(claim_ctx) == c, "R8 claim_ctx", 128'(claim_ctx), 128'(c));
    chk(cmpl_stb === ms, "R9 cmpl_stb", 128'(cmpl_stb), 128'(ms));
    if (ms) begin
      chk(int'(cmpl_ctx) == c, "R9 cmpl_ctx", 128'(cmpl_ctx), 128'(c));
      chk(longint'(cmpl_id) == d, "R9 cmpl_id", 128'(cmpl_id), 128'(d));
    end
    rd = '0;
    case (k)
      M_PRIO: begin
        rd = 32'(prio_m[idx]);
        if (v && w) prio_m[idx] = int'(d % 8);
      end
      M_PEND: for (int b = 0; b < 32; b++) if (idx*32 + b < NS) rd[b] = tb_pend[idx*32 + b];
      M_EN: begin
        for (int b = 0; b < 32; b++) if (idx*32 + b < NS) rd[b] = en_m[c][idx*32 + b];
        if (v && w) for (int b = 0; b < 32; b++)
          if (idx*32 + b < NS) en_m[c][idx*32 + b] = d[b];
      end
      M_THR: begin
        rd = 32'(thr_m[c]);
        if (v && w && d <= NL) thr_m[c] = int'(d);
      end
      M_CLAIM: rd = 32'(tb_cid);
      default: rd = '0;
    endcase
    exp_rv = v;
    exp_rd = (v && !w) ? rd : 32'd0;
    exp_tag = (v && !w) ? tg : "R1 write response data";
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(rsp_valid === 1'b0, "R11 rsp_valid in reset", 128'(rsp_valid), 0);
    chk(src_prio === '0, "R11 priorities in reset", 128'(src_prio), 0);
    chk(src_en === '0, "R11 enables in reset", 128'(src_en), 0);
    chk(ctx_thr === '0, "R11 thresholds in reset", 128'(ctx_thr), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    // R3 priorities
    step(1, 1, PB + 4*4, 'hFFFF_FFFD);
    step(1, 0, PB + 4*4, 0);
    step(1, 1, PB + 4*38, 6);
    step(1, 0, PB + 4*38, 0);
    step(1, 1, PB, 'h12);
    step(1, 0, PB, 0);
    // R10 outside priority window
    step(1, 1, PB + 4*39, 5);
    step(1, 0, PB + 4*39, 0);
    step(1, 1, 0, 7);
    step(1, 0, 0, 0);
    // R2 misaligned
    step(1, 1, PB + 4 + 2, 7);
    step(1, 0, PB + 4, 0);
    step(1, 0, PB + 4*4 + 1, 0);
    // R4 pending, input changed in the read cycle
    tb_pend = 40'hA5_1234_5678;
    step(1, 0, QB, 0);
    step(1, 0, QB + 4, 0);
    tb_pend = 40'hFF_0F0F_F0F0;
    step(1, 0, QB + 4, 0);
    step(1, 1, QB, 'hFFFF_FFFF);
    step(1, 0, QB, 0);
    step(1, 0, QB + 8, 0);
    // R5 / R6 enables
    step(1, 1, EB, 'hDEAD_BEEF);
    step(1, 1, EB + 4, 'hFFFF_FFFF);
    step(1, 1, EB + ES + 4, 'h5A);
    step(1, 0, EB, 0);
    step(1, 0, EB + 4, 0);
    step(1, 0, EB + ES + 4, 0);
    step(1, 1, EB + 8, 'h1234);
    step(1, 0, EB + 8, 0);
    step(1, 1, EB + ES + 'h7C, 'hFFFF);
    step(1, 0, EB + ES, 0);
    // R7 thresholds
    step(1, 1, CB, 5);
    step(1, 0, CB, 0);
    step(1, 1, CB, 8);
    step(1, 0, CB, 0);
    step(1, 1, CB + CS, 7);
    step(1, 1, CB + CS, 'hFFFF_FFFF);
    step(1, 0, CB + CS, 0);
    // R8 claims back to back, R9 completes
    tb_cid = 17;
    step(1, 0, CB + 4, 0);
    tb_cid = 3;
    step(1, 0, CB + CS + 4, 0);
    step(1, 0, CB + CS + 4, 0);
    step(1, 1, CB + 4, 3);
    step(1, 1, CB + CS + 4, 39);
    step(1, 1, CB + 4, 40);
    step(1, 1, CB + 4, 'h100);
    step(1, 1, CB + 4, 0);
    step(1, 0, CB + 5, 0);
    step(1, 1, CB + CS + 6, 2);
    step(1, 0, CB + 8, 0);
    step(1, 1, CB + 8, 3);
    step(1, 0, 'h300000, 0);
    step(0, 0, CB + 4, 0);
    step(0, 1, CB + 4, 1);
    // mixed sweep
    for (int i = 0; i < 800; i++) begin
      longint a, d;
      case ($urandom_range(0, 5))
        0: a = PB + 4 * longint'($urandom_range(0, 41));
        1: a = QB + 4 * longint'($urandom_range(0, 3));
        2: a = EB + longint'($urandom_range(0, NC*ES + 8));
        3: a = CB + CS * longint'($urandom_range(0, 2)) + 4 * longint'($urandom_range(0, 2));
        4: a = longint'($urandom_range(0, 'hFFFFFF));
        default: a = PB + 4 * longint'($urandom_range(0, 3));
      endcase
      if ($urandom_range(0, 7) == 0) a = a + longint'($urandom_range(1, 3));
      a = a % 'h1000000;
      d = ($urandom_range(0, 1) == 0) ? longint'($urandom_range(0, 45)) : longint'($urandom);
      tb_pend = {$urandom, $urandom};
      tb_cid = $urandom_range(0, 39);
      step($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, d);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule